// File: doc/BRIEF.md
# Reset Release Sequencer with Retries

This block brings a graphics processor and a host processor out of reset in a fixed order once power and clocks are known to be good. After a start request it holds both reset lines low for a programmable number of cycles. It then releases the graphics reset and waits for that part to report that its reset has finished. Next it waits for the link between the two parts to report the fully active (L0) state. Only then does it release the host reset, and it waits for a single-cycle strobe showing that host software has asked for the power-up cause.

Each of the three waits has its own timeout, counted in clock cycles. When a wait runs out, the block drives both resets low again, raises a one-cycle retry pulse and starts over from the hold phase. The whole sequence can run five times, which is the first attempt plus four retries. If the fifth attempt also times out, the block stops in a boot-error state and shows a code for the stage that failed. If the strobe arrives, the block sets its done flag and keeps both parts out of reset. A new start request re-runs the sequence from attempt zero from either end state.

Top module: `boot_release_seq`

## Requirements
- R1: While reset is applied, and in the idle state after it, both reset outputs are low (asserted), done and error are 0, the error code is 0x00 and the attempt count is 0.
- R2: A start request in the idle, done or error state clears done, error, the error code and the attempt count on the next edge and drives both reset outputs low. The graphics reset output then rises exactly max(hold,1) cycles later.
- R3: The host reset output never rises before the graphics reset output. It rises on the same edge at which the link-active input is first sampled high after the reset-done input has been seen.
- R4: Each wait stage is cleared on entry and passes only if its completion input is sampled high within max(T,1) clock edges after entry, where T is that stage's own timeout value.
- R5: A timeout while retries remain drives both reset outputs low on the next edge, raises the retry pulse for exactly one cycle, increments the attempt count by one and starts a new hold phase.
- R6: At most five attempts are made. A timeout in attempt 4 (the fifth attempt) enters the error state: error is 1, the attempt count is 4, both resets are low, and the code is 0x08 for missing reset-done, 0x09 for no link-active and 0x0A for no host strobe. This state is held until a start request.
- R7: A host strobe sampled in the host wait sets done to 1 and holds both reset outputs high until the next start request.
- R8: A start request is ignored while the hold or any wait stage is in progress.
- R9: When a completion input is sampled on the same edge as the stage's last allowed cycle, the completion wins over the timeout.
- R10: The error code output is 0x00 whenever the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| gpu_done_i | input | 1 | Graphics reset-finished indication |
| link_l0_i | input | 1 | Link reached the active L0 state |
| host_req_i | input | 1 | Host power-up-cause request strobe |
| hold_cyc_i | input | TW | Reset hold length before each attempt, in cycles |
| tmo_gpu_i | input | TW | Timeout for the reset-done wait, in cycles |
| tmo_link_i | input | TW | Timeout for the link wait, in cycles |
| tmo_host_i | input | TW | Timeout for the host strobe wait, in cycles |
| gpu_rst_n_o | output | 1 | Graphics reset, active low, registered |
| cpu_rst_n_o | output | 1 | Host reset, active low, registered |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 1 | Boot error after the last attempt |
| err_code_o | output | CW | Failing stage code (0x08, 0x09, 0x0A) |
| attempt_o | output | AW | Index of the current attempt, 0 to 4 |
| retry_pulse_o | output | 1 | One-cycle pulse on each timeout that is retried |

## Verification
The bench builds the block with TW=8 and keeps the default of four retries with AW=3. An 8-bit timer lets every timeout and hold value stay in single or low double digits, so a run of five failed attempts takes a few hundred cycles. It also lets the bench reach the boundaries directly: a delay equal to a timeout, a delay one past it, and zero limits that must act as one cycle. The bench models the completion inputs from the reset outputs it observes, which is enough to place failures in any chosen stage and on any chosen attempt, including a recovery on the fifth attempt.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_WGPU  = 3'd2,
    ST_WLINK = 3'd3,
    ST_WHOST = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAIL  = 3'd6
  } brs_state_e;

  localparam logic [7:0] CODE_NONE = 8'h00;
  localparam logic [7:0] CODE_GPU  = 8'h08;
  localparam logic [7:0] CODE_LINK = 8'h09;
  localparam logic [7:0] CODE_HOST = 8'h0A;

  // Failure code belonging to the wait stage that timed out
  function automatic logic [7:0] stage_code(input brs_state_e st);
    case (st)
      ST_WGPU:  return CODE_GPU;
      ST_WLINK: return CODE_LINK;
      ST_WHOST: return CODE_HOST;
      default:  return CODE_NONE;
    endcase
  endfunction

  // Graphics part is out of reset in these states
  function automatic logic gpu_released(input brs_state_e st);
    return (st == ST_WGPU) || (st == ST_WLINK) || (st == ST_WHOST) || (st == ST_DONE);
  endfunction

  // Host part is out of reset in these states
  function automatic logic cpu_released(input brs_state_e st);
    return (st == ST_WHOST) || (st == ST_DONE);
  endfunction

  // States in which a start request is accepted
  function automatic logic accepts_start(input brs_state_e st);
    return (st == ST_IDLE) || (st == ST_DONE) || (st == ST_FAIL);
  endfunction

endpackage

// File: rtl/brs_stage_timer.sv
module brs_stage_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  output logic          expired_o
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q;

  // A stage lasting max(lim,1) edges: the last edge sees cnt == lim-1
  function automatic logic is_last(input logic [TW-1:0] cnt, input logic [TW-1:0] lim);
    logic [TW:0] ext;
    ext = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
    return ext >= {1'b0, lim};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = is_last(cnt_q, lim_i);

endmodule

// File: rtl/brs_attempt_ctr.sv
module brs_attempt_ctr #(
  parameter int AW      = 3,
  parameter int RETRIES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] count_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(RETRIES);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != LAST_IDX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == LAST_IDX);

endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          gpu_done_i,
  input  logic          link_l0_i,
  input  logic          host_req_i,
  input  logic          expired_i,
  input  logic          last_i,
  output brs_state_e    state_o,
  output logic          stage_clr_o,
  output logic          att_clr_o,
  output logic          att_inc_o,
  output logic          tmo_evt_o,
  output logic          gpu_rst_n_o,
  output logic          cpu_rst_n_o,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] err_code_o,
  output logic          retry_o
);
  brs_state_e    st_q, st_d;
  logic          gpu_q, cpu_q, done_q, err_q, retry_q;
  logic [CW-1:0] code_q;
  logic          timeout;
  logic          launch;
  logic          retry_d;

  always_comb begin
    st_d    = st_q;
    timeout = 1'b0;
    launch  = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          st_d   = ST_HOLD;
          launch = 1'b1;
        end
      end
      ST_HOLD: begin
        if (expired_i) st_d = ST_WGPU;
      end
      ST_WGPU: begin
        if (gpu_done_i)     st_d = ST_WLINK;
        else if (expired_i) timeout = 1'b1;
      end
      ST_WLINK: begin
        if (link_l0_i)      st_d = ST_WHOST;
        else if (expired_i) timeout = 1'b1;
      end
      ST_WHOST: begin
        if (host_req_i)     st_d = ST_DONE;
        else if (expired_i) timeout = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (timeout) st_d = last_i ? ST_FAIL : ST_HOLD;
  end

  assign retry_d = timeout && !last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      gpu_q   <= 1'b0;
      cpu_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      retry_q <= 1'b0;
      code_q  <= '0;
    end else begin
      st_q    <= st_d;
      gpu_q   <= gpu_released(st_d);
      cpu_q   <= cpu_released(st_d);
      done_q  <= (st_d == ST_DONE);
      err_q   <= (st_d == ST_FAIL);
      retry_q <= retry_d;
      if (launch) begin
        code_q <= '0;
      end else if (timeout && last_i) begin
        code_q <= CW'(stage_code(st_q));
      end
    end
  end

  assign state_o     = st_q;
  assign stage_clr_o = (st_d != st_q) || retry_d;
  assign att_clr_o   = launch;
  assign att_inc_o   = retry_d;
  assign tmo_evt_o   = timeout;
  assign gpu_rst_n_o = gpu_q;
  assign cpu_rst_n_o = cpu_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;
  assign retry_o     = retry_q;

endmodule

// File: rtl/boot_release_seq.sv
module boot_release_seq
  import brs_pkg::*;
#(
  parameter int TW      = 16,
  parameter int RETRIES = 4,
  parameter int AW      = 3,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          gpu_done_i,
  input  logic          link_l0_i,
  input  logic          host_req_i,
  input  logic [TW-1:0] hold_cyc_i,
  input  logic [TW-1:0] tmo_gpu_i,
  input  logic [TW-1:0] tmo_link_i,
  input  logic [TW-1:0] tmo_host_i,
  output logic          gpu_rst_n_o,
  output logic          cpu_rst_n_o,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] err_code_o,
  output logic [AW-1:0] attempt_o,
  output logic          retry_pulse_o
);
  localparam int ATT_LIMIT = 1 << AW;

  brs_state_e    state_w;
  logic [TW-1:0] stage_lim_w;
  logic          stage_clr_w;
  logic          expired_w;
  logic          last_w;
  logic          att_clr_w;
  logic          att_inc_w;
  logic          tmo_evt;

  generate
    if (RETRIES >= ATT_LIMIT) begin : g_bad_width
      initial $error("attempt counter too narrow for the retry count");
    end
  endgenerate

  // Limit of the stage currently running
  always_comb begin
    case (state_w)
      ST_HOLD:  stage_lim_w = hold_cyc_i;
      ST_WGPU:  stage_lim_w = tmo_gpu_i;
      ST_WLINK: stage_lim_w = tmo_link_i;
      ST_WHOST: stage_lim_w = tmo_host_i;
      default:  stage_lim_w = '0;
    endcase
  end

  brs_stage_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (stage_clr_w),
    .lim_i     (stage_lim_w),
    .expired_o (expired_w)
  );

  brs_attempt_ctr #(.AW(AW), .RETRIES(RETRIES)) u_att (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (att_clr_w),
    .inc_i   (att_inc_w),
    .count_o (attempt_o),
    .last_o  (last_w)
  );

  brs_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .gpu_done_i  (gpu_done_i),
    .link_l0_i   (link_l0_i),
    .host_req_i  (host_req_i),
    .expired_i   (expired_w),
    .last_i      (last_w),
    .state_o     (state_w),
    .stage_clr_o (stage_clr_w),
    .att_clr_o   (att_clr_w),
    .att_inc_o   (att_inc_w),
    .tmo_evt_o   (tmo_evt),
    .gpu_rst_n_o (gpu_rst_n_o),
    .cpu_rst_n_o (cpu_rst_n_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o),
    .retry_o     (retry_pulse_o)
  );

endmodule

// File: rtl/boot_release_seq_chk.sv
module boot_release_seq_chk #(
  parameter int RETRIES = 4,
  parameter int AW      = 3,
  parameter int CW      = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          link_l0_i,
  input logic          tmo_evt,
  input logic          gpu_rst_n_o,
  input logic          cpu_rst_n_o,
  input logic          done_o,
  input logic          err_o,
  input logic [CW-1:0] err_code_o,
  input logic [AW-1:0] attempt_o,
  input logic          retry_pulse_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(RETRIES);

  assert_cpu_after_gpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n_o |-> gpu_rst_n_o);

  assert_cpu_needs_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n_o) |-> $past(link_l0_i));

  assert_timeout_reacts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (retry_pulse_o || err_o) && !gpu_rst_n_o && !cpu_rst_n_o);

  assert_retry_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse_o |=> !retry_pulse_o);

  assert_retry_resets_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse_o |-> !gpu_rst_n_o && !cpu_rst_n_o && !done_o);

  assert_fail_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !gpu_rst_n_o && !cpu_rst_n_o && (attempt_o == LAST_IDX) && !done_o);

  assert_fail_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o == 8'h08) || (err_code_o == 8'h09) || (err_code_o == 8'h0A));

  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o && $stable(err_code_o));

  assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> gpu_rst_n_o && cpu_rst_n_o);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  assert_code_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_o |-> (err_code_o == '0));

endmodule

bind boot_release_seq boot_release_seq_chk #(
  .RETRIES (RETRIES),
  .AW      (AW),
  .CW      (CW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .link_l0_i     (link_l0_i),
  .tmo_evt       (tmo_evt),
  .gpu_rst_n_o   (gpu_rst_n_o),
  .cpu_rst_n_o   (cpu_rst_n_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .err_code_o    (err_code_o),
  .attempt_o     (attempt_o),
  .retry_pulse_o (retry_pulse_o)
);

// File: tb/boot_release_seq_tb.sv
module boot_release_seq_tb;
  localparam int TW = 8;
  localparam int AW = 3;
  localparam int CW = 8;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          gpu_done_i = 1'b0;
  logic          link_l0_i = 1'b0;
  logic          host_req_i = 1'b0;
  logic [TW-1:0] hold_cyc_i = '0;
  logic [TW-1:0] tmo_gpu_i = '0;
  logic [TW-1:0] tmo_link_i = '0;
  logic [TW-1:0] tmo_host_i = '0;
  logic          gpu_rst_n_o, cpu_rst_n_o, done_o, err_o, retry_pulse_o;
  logic [CW-1:0] err_code_o;
  logic [AW-1:0] attempt_o;

  always #10 clk = ~clk;

  boot_release_seq #(.TW(TW), .RETRIES(4), .AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .gpu_done_i(gpu_done_i), .link_l0_i(link_l0_i), .host_req_i(host_req_i),
    .hold_cyc_i(hold_cyc_i), .tmo_gpu_i(tmo_gpu_i), .tmo_link_i(tmo_link_i),
    .tmo_host_i(tmo_host_i), .gpu_rst_n_o(gpu_rst_n_o), .cpu_rst_n_o(cpu_rst_n_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
    .attempt_o(attempt_o), .retry_pulse_o(retry_pulse_o)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // delay 0 means the completion never arrives
  typedef struct packed {
    logic [7:0] hold;
    logic [7:0] tg, tl, th;
    logic [7:0] dg, dl, dh;
    logic [1:0] bad;   // stage forced to never complete: 1 gpu, 2 link, 3 host
    logic [2:0] nbad;  // number of leading attempts with that stage forced
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 8'd4, 8'd4, 8'd4, 8'd2, 8'd2, 8'd2, 2'd0, 3'd0},  // plain success
    '{8'd1, 8'd4, 8'd5, 8'd6, 8'd4, 8'd5, 8'd6, 2'd0, 3'd0},  // delay == limit R9
    '{8'd1, 8'd4, 8'd4, 8'd4, 8'd5, 8'd1, 8'd1, 2'd0, 3'd0},  // gpu one late
    '{8'd2, 8'd3, 8'd3, 8'd3, 8'd1, 8'd0, 8'd1, 2'd0, 3'd0},  // link never
    '{8'd1, 8'd3, 8'd3, 8'd6, 8'd1, 8'd1, 8'd7, 2'd0, 3'd0},  // host one late
    '{8'd3, 8'd5, 8'd5, 8'd5, 8'd2, 8'd3, 8'd1, 2'd2, 3'd2},  // two link failures
    '{8'd1, 8'd4, 8'd4, 8'd4, 8'd1, 8'd1, 8'd3, 2'd3, 3'd4},  // saved on last try
    '{8'd0, 8'd0, 8'd3, 8'd2, 8'd1, 8'd1, 8'd2, 2'd0, 3'd0},  // zero limit acts as 1
    '{8'd1, 8'd3, 8'd3, 8'd0, 8'd1, 8'd1, 8'd2, 2'd0, 3'd0},  // zero host limit fails
    '{8'd2, 8'd6, 8'd6, 8'd6, 8'd2, 8'd2, 8'd2, 2'd1, 3'd1}   // one gpu failure
  };

  function automatic int eff(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic bit passes(input int d, input int t);
    return (d != 0) && (d <= eff(t));
  endfunction

  // Outcome from the requirements: R4, R6, R9
  task automatic predict(input vec_t v, output bit ok, output int att, output int code);
    ok = 0; att = 0; code = 0;
    for (int a = 0; a < 5; a++) begin
      int dg, dl, dh;
      dg = (a < v.nbad && v.bad == 2'd1) ? 0 : int'(v.dg);
      dl = (a < v.nbad && v.bad == 2'd2) ? 0 : int'(v.dl);
      dh = (a < v.nbad && v.bad == 2'd3) ? 0 : int'(v.dh);
      att = a;
      if (!passes(dg, v.tg))      code = 8'h08;
      else if (!passes(dl, v.tl)) code = 8'h09;
      else if (!passes(dh, v.th)) code = 8'h0A;
      else begin ok = 1; code = 0; return; end
    end
  endtask

  // Responder state, updated at each falling edge from the observed outputs
  int sg = 0, sl = 0, sh = 0;
  int cur_att = 0;
  int retries_seen = 0;

  task automatic respond(input vec_t v);
    int dg, dl, dh;
    if (retry_pulse_o) begin
      cur_att++;
      retries_seen++;
    end
    sl = (!gpu_rst_n_o || !gpu_done_i) ? 0 : sl + 1;
    sg = (!gpu_rst_n_o) ? 0 : sg + 1;
    sh = (!cpu_rst_n_o) ? 0 : sh + 1;
    dg = (cur_att < v.nbad && v.bad == 2'd1) ? 0 : int'(v.dg);
    dl = (cur_att < v.nbad && v.bad == 2'd2) ? 0 : int'(v.dl);
    dh = (cur_att < v.nbad && v.bad == 2'd3) ? 0 : int'(v.dh);
    gpu_done_i = gpu_rst_n_o && (dg != 0) && (sg >= dg);
    link_l0_i  = gpu_rst_n_o && (dl != 0) && (sl >= dl);
    host_req_i = cpu_rst_n_o && (dh != 0) && (sh == dh);
  endtask

  task automatic apply_cfg(input vec_t v);
    hold_cyc_i = v.hold; tmo_gpu_i = v.tg; tmo_link_i = v.tl; tmo_host_i = v.th;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    bit ok; int att, code, guard;
    predict(v, ok, att, code);
    apply_cfg(v);
    @(negedge clk);
    sg = 0; sl = 0; sh = 0; cur_att = 0; retries_seen = 0;
    gpu_done_i = 0; link_l0_i = 0; host_req_i = 0;
    pulse_start();
    // R2: cleared on the edge after start
    check($sformatf("R2 vec%0d done cleared", idx), int'(done_o), 0);
    check($sformatf("R10 vec%0d code cleared", idx), int'(err_code_o), 0);
    guard = 0;
    while (!done_o && !err_o && guard < 5000) begin
      respond(v);
      @(negedge clk);
      guard++;
    end
    check($sformatf("R7 vec%0d done", idx), int'(done_o), int'(ok));
    check($sformatf("R6 vec%0d error", idx), int'(err_o), int'(!ok));
    check($sformatf("R6 vec%0d code", idx), int'(err_code_o), code);
    check($sformatf("R5 vec%0d attempt", idx), int'(attempt_o), att);
    check($sformatf("R5 vec%0d retry pulses", idx), retries_seen, att);
    check($sformatf("R7 vec%0d gpu reset out", idx), int'(gpu_rst_n_o), int'(ok));
    check($sformatf("R7 vec%0d cpu reset out", idx), int'(cpu_rst_n_o), int'(ok));
    gpu_done_i = 0; link_l0_i = 0; host_req_i = 0;
  endtask

  // Counts low cycles of the graphics reset from the current falling edge
  task automatic count_low(output int n);
    n = 0;
    while (!gpu_rst_n_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    vec_t d;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 gpu reset low", int'(gpu_rst_n_o), 0);
    check("R1 cpu reset low", int'(cpu_rst_n_o), 0);
    check("R1 flags", int'({done_o, err_o}), 0);
    check("R1 code and attempt", int'({err_code_o, attempt_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle holds resets", int'({gpu_rst_n_o, cpu_rst_n_o}), 0);

    // R2: hold lengths 5 and 0
    d = '{8'd5, 8'd9, 8'd9, 8'd9, 8'd0, 8'd0, 8'd0, 2'd0, 3'd0};
    apply_cfg(d);
    pulse_start();
    count_low(n);
    check("R2 hold of 5", n, 5);
    hold_cyc_i = 8'd3; tmo_gpu_i = 8'd2;
    // R5: hold after a retry pulse
    while (!retry_pulse_o) @(negedge clk);
    check("R5 cpu low on retry", int'(cpu_rst_n_o), 0);
    count_low(n);
    check("R5 hold after retry", n, 3);
    // R8: start in the gpu wait is ignored
    tmo_gpu_i = 8'd40;
    while (!retry_pulse_o) @(negedge clk);
    count_low(n);
    repeat (2) @(negedge clk);
    pulse_start();
    check("R8 start ignored gpu reset", int'(gpu_rst_n_o), 1);
    check("R8 start ignored attempt", int'(attempt_o), 2);
    while (!err_o) @(negedge clk);
    check("R6 gpu never code", int'(err_code_o), 8'h08);
    // R2: restart from error
    hold_cyc_i = 8'd0;
    pulse_start();
    check("R2 attempt cleared", int'(attempt_o), 0);
    check("R2 error cleared", int'(err_o), 0);
    count_low(n);
    check("R2 hold of 0 acts as 1", n, 1);
    hold_cyc_i = 8'd2;
    while (!err_o) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(i, VECS[i]);
    end

    // R2: start from done drives resets low
    pulse_start();
    check("R2 restart from done resets", int'({gpu_rst_n_o, cpu_rst_n_o, done_o}), 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule